// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider settings of one PLL without letting a half-programmed clock escape. A request carries the input divider, the feedback multiplier, the output divider and a flag that says whether the PLL has a bandwidth field. The block checks the request, then runs a fixed sequence. It moves the clock mux onto the reference, puts the PLL in reset and writes the encoded fields. It holds reset for a set time, waits for lock, and only then returns the mux to the PLL output.

The range check runs on the raw request in the cycle the request is presented. The reference frequency is 24 MHz. The VCO must lie between 440 and 2200 MHz inclusive. The output must lie between 30 and 2200 MHz inclusive. The output divider must be 1 or an even number of at most 16. The check uses only comparisons of integer products, so no divider is built. A rejected request leaves every PLL control output as it was. A request that never sees lock ends in an error, and the mux is left on the reference.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, `pllSlow`, `pllReset`, `busy`, `done` and `err` are low, and all four field outputs are zero.
- R2: The edge that accepts a request raises `pllSlow`. `pllReset` rises on the next edge. The field outputs change only while `pllReset` is high.
- R3: On the field write, `nrField` = NR-1, `noField` = NO-1 (4 bits) and `nfField` = NF-1 (13 bits).
- R4: If the bandwidth flag was set with the request, `bwField` is written with (NF>>1)-1 (12 bits). If the flag was clear, `bwField` keeps its previous value.
- R5: `pllReset` falls exactly HOLD_CYC clock cycles after the cycle in which the fields were written.
- R6: A request whose NO is neither 1 nor an even value up to 16 is rejected. `err` pulses for one cycle on the edge that samples the request, and no PLL control output changes.
- R7: A request is rejected in the same way as in R6 when 24·NF/NR falls outside 440..2200 MHz or 24·NF/(NR·NO) falls outside 30..2200 MHz. Both ranges are inclusive.
- R8: `pllSlow` falls only on an edge at which `pllLock` was sampled high. `done` pulses for one cycle on that same edge.
- R9: `busy` is high from the accepting edge until the edge that raises `done` or `err`. A request presented while `busy` is high is ignored. Each accepted request yields exactly one `done` or `err`.
- R10: If lock does not appear within LOCK_TMO cycles after `pllReset` falls, `err` pulses and `pllSlow` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqNr | input | 6 | Input divider NR |
| reqNf | input | 13 | Feedback multiplier NF |
| reqNo | input | 5 | Output divider NO |
| reqBwAdj | input | 1 | PLL has a bandwidth field to write |
| pllLock | input | 1 | Lock status from the PLL |
| pllSlow | output | 1 | Mux select: 1 = reference, 0 = PLL output |
| pllReset | output | 1 | PLL reset |
| nrField | output | 6 | Encoded NR-1 |
| noField | output | 4 | Encoded NO-1 |
| nfField | output | 13 | Encoded NF-1 |
| bwField | output | 12 | Encoded bandwidth (NF>>1)-1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on rejection or lock timeout |

## Verification
The lock timeout is the hardest case to reach from the ports, because a healthy PLL always locks. The bench model of the PLL raises lock a fixed number of cycles after reset falls, and an enable on that model holds lock low for one request. This drives the sequencer into its timeout path, and the bench then sends a normal request while the mux is still on the reference. The request that arrives during a busy sequence is also hard to reach. It is placed a few cycles after an accepted request, and the scoreboard shows that it produced no outcome and changed no field.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef struct packed {
    logic latchReq;
    logic setSlow;
    logic clrSlow;
    logic setRst;
    logic clrRst;
    logic wrFields;
    logic cntClr;
  } seq_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTON,
    ST_WRITE,
    ST_HOLD,
    ST_WAITLK
  } seq_state_t;

endpackage

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
#(
  parameter int NR_W     = 6,
  parameter int NF_W     = 13,
  parameter int NO_W     = 5,
  parameter int NOF_W    = 4,
  parameter int BW_W     = 12,
  parameter int CNT_W    = 16,
  parameter int REF_MHZ  = 24,
  parameter int VCO_MIN  = 440,
  parameter int VCO_MAX  = 2200,
  parameter int OUT_MIN  = 30,
  parameter int OUT_MAX  = 2200,
  parameter int HOLD_CYC = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       stb,
  input  logic [NR_W-1:0]   reqNr,
  input  logic [NF_W-1:0]   reqNf,
  input  logic [NO_W-1:0]   reqNo,
  input  logic              reqBwAdj,
  output logic              reqOk,
  output logic [CNT_W-1:0]  cnt,
  output logic              slowQ,
  output logic              rstQ,
  output logic [NR_W-1:0]   nrEnc,
  output logic [NOF_W-1:0]  noEnc,
  output logic [NF_W-1:0]   nfEnc,
  output logic [BW_W-1:0]   bwEnc
);

  localparam int NO_MAX = 1 << NOF_W;

  logic [NR_W-1:0] lNr;
  logic [NF_W-1:0] lNf;
  logic [NO_W-1:0] lNo;
  logic            lBw;

  logic [31:0] fRef, nrX, nrNoX;
  logic        noOk, rangeOk;

  always_comb begin
    fRef    = 32'(reqNf) * 32'(REF_MHZ);
    nrX     = 32'(reqNr);
    nrNoX   = 32'(reqNr) * 32'(reqNo);
    noOk    = (reqNo == NO_W'(1)) ||
              ((reqNo != '0) && !reqNo[0] && (32'(reqNo) <= 32'(NO_MAX)));
    rangeOk = (reqNr != '0) &&
              (fRef >= 32'(VCO_MIN) * nrX) && (fRef <= 32'(VCO_MAX) * nrX) &&
              (fRef >= 32'(OUT_MIN) * nrNoX) && (fRef <= 32'(OUT_MAX) * nrNoX);
    reqOk   = noOk && rangeOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lNr <= '0; lNf <= '0; lNo <= '0; lBw <= 1'b0;
      slowQ <= 1'b0; rstQ <= 1'b0;
      nrEnc <= '0; noEnc <= '0; nfEnc <= '0; bwEnc <= '0;
      cnt <= '0;
    end else begin
      if (stb.latchReq) begin
        lNr <= reqNr; lNf <= reqNf; lNo <= reqNo; lBw <= reqBwAdj;
      end
      if (stb.setSlow)      slowQ <= 1'b1;
      else if (stb.clrSlow) slowQ <= 1'b0;
      if (stb.setRst)       rstQ <= 1'b1;
      else if (stb.clrRst)  rstQ <= 1'b0;
      if (stb.wrFields) begin
        nrEnc <= lNr - NR_W'(1);
        noEnc <= NOF_W'(lNo - NO_W'(1));
        nfEnc <= lNf - NF_W'(1);
        if (lBw) bwEnc <= BW_W'((lNf >> 1) - NF_W'(1));
      end
      cnt <= stb.cntClr ? '0 : cnt + CNT_W'(1);
    end
  end

  // Independent count of cycles since the last field write, for checking
  logic [CNT_W:0] sinceWr;
  always_ff @(posedge clk) begin
    if (!rstN)              sinceWr <= '0;
    else if (stb.wrFields)  sinceWr <= '0;
    else if (sinceWr != '1) sinceWr <= sinceWr + (CNT_W+1)'(1);
  end

  // R2
  fields_under_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({nrEnc, noEnc, nfEnc, bwEnc}) |-> rstQ);

  // R5
  hold_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstQ) |-> (sinceWr == (CNT_W+1)'(HOLD_CYC)));

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HOLD_CYC = 2500,
  parameter int LOCK_TMO = 50000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqOk,
  input  logic             lock,
  input  logic [CNT_W-1:0] cnt,
  output seq_strobe_t      stb,
  output logic             busy,
  output logic             doneQ,
  output logic             errQ
);

  seq_state_t st, nxt;
  logic holdEnd, lockEnd;

  always_comb begin
    holdEnd = (cnt == CNT_W'(HOLD_CYC - 1));
    lockEnd = (cnt == CNT_W'(LOCK_TMO - 1));
    stb = '0;
    nxt = st;
    unique case (st)
      ST_IDLE: if (reqValid && reqOk) begin
        stb.latchReq = 1'b1;
        stb.setSlow  = 1'b1;
        nxt = ST_RSTON;
      end
      ST_RSTON: begin
        stb.setRst = 1'b1;
        nxt = ST_WRITE;
      end
      ST_WRITE: begin
        stb.wrFields = 1'b1;
        stb.cntClr   = 1'b1;
        nxt = ST_HOLD;
      end
      ST_HOLD: if (holdEnd) begin
        stb.clrRst = 1'b1;
        stb.cntClr = 1'b1;
        nxt = ST_WAITLK;
      end
      ST_WAITLK: begin
        if (lock) begin
          stb.clrSlow = 1'b1;
          nxt = ST_IDLE;
        end else if (lockEnd) begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      st    <= nxt;
      doneQ <= (st == ST_WAITLK) && lock;
      errQ  <= ((st == ST_IDLE) && reqValid && !reqOk) ||
               ((st == ST_WAITLK) && !lock && lockEnd);
    end
  end

  assign busy = (st != ST_IDLE);

  // R9
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ || errQ) |-> !(doneQ && errQ) && !busy);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int NR_W     = 6,
  parameter int NF_W     = 13,
  parameter int NO_W     = 5,
  parameter int NOF_W    = 4,
  parameter int BW_W     = 12,
  parameter int HOLD_CYC = 2500,
  parameter int LOCK_TMO = 50000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [NR_W-1:0]  reqNr,
  input  logic [NF_W-1:0]  reqNf,
  input  logic [NO_W-1:0]  reqNo,
  input  logic             reqBwAdj,
  input  logic             pllLock,
  output logic             pllSlow,
  output logic             pllReset,
  output logic [NR_W-1:0]  nrField,
  output logic [NOF_W-1:0] noField,
  output logic [NF_W-1:0]  nfField,
  output logic [BW_W-1:0]  bwField,
  output logic             busy,
  output logic             done,
  output logic             err
);

  localparam int CNT_MAX = (HOLD_CYC > LOCK_TMO) ? HOLD_CYC : LOCK_TMO;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_strobe_t      stb;
  logic             reqOk;
  logic [CNT_W-1:0] cnt;

  pll_seq_ctrl #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC), .LOCK_TMO(LOCK_TMO)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOk(reqOk), .lock(pllLock),
    .cnt(cnt), .stb(stb), .busy(busy), .doneQ(done), .errQ(err)
  );

  pll_seq_dp #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .NOF_W(NOF_W), .BW_W(BW_W),
               .CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqNr(reqNr), .reqNf(reqNf), .reqNo(reqNo),
    .reqBwAdj(reqBwAdj), .reqOk(reqOk), .cnt(cnt), .slowQ(pllSlow), .rstQ(pllReset),
    .nrEnc(nrField), .noEnc(noField), .nfEnc(nfField), .bwEnc(bwField)
  );

  // R8
  normal_after_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pllSlow) |-> $past(pllLock) && done);

  // R6
  err_keeps_mux_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $stable(pllSlow) && $stable(pllReset));

  // R2
  accept_goes_slow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> pllSlow && !pllReset);

endmodule

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;

  localparam int HOLD = 12;
  localparam int TMO  = 60;
  localparam int LDLY = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [5:0]  reqNr = '0;
  logic [12:0] reqNf = '0;
  logic [4:0]  reqNo = '0;
  logic reqBwAdj = 1'b0;
  logic pllLock = 1'b0;
  logic pllSlow, pllReset, busy, done, err;
  logic [5:0]  nrField;
  logic [3:0]  noField;
  logic [12:0] nfField;
  logic [11:0] bwField;

  always #2 clk = ~clk;

  pll_reprog_seq #(.HOLD_CYC(HOLD), .LOCK_TMO(TMO)) u_pll_reprog_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqNr(reqNr), .reqNf(reqNf),
    .reqNo(reqNo), .reqBwAdj(reqBwAdj), .pllLock(pllLock), .pllSlow(pllSlow),
    .pllReset(pllReset), .nrField(nrField), .noField(noField), .nfField(nfField),
    .bwField(bwField), .busy(busy), .done(done), .err(err)
  );

  // PLL model: lock rises LDLY cycles after reset falls when enabled
  logic lockEn = 1'b1;
  int   lcnt = 0;
  always @(posedge clk) begin
    if (!rstN || pllReset) begin
      pllLock <= 1'b0; lcnt <= 0;
    end else if (lockEn) begin
      if (lcnt == LDLY) pllLock <= 1'b1;
      else lcnt <= lcnt + 1;
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct {
    bit isErr;
    int nrE, noE, nfE, bwE;
    bit slowE;
  } exp_t;
  exp_t q[$];

  int  mNr = 0, mNo = 0, mNf = 0, mBw = 0;
  bit  mSlow = 0;

  function automatic bit inRange(int nr, int nf, int no);
    real vco, fo;
    if (!(no == 1 || (no != 0 && no % 2 == 0 && no <= 16))) return 0;
    if (nr == 0) return 0;
    vco = 24.0 * nf / nr;
    fo  = vco / no;
    return (vco >= 440.0) && (vco <= 2200.0) && (fo >= 30.0) && (fo <= 2200.0);
  endfunction

  task automatic send(input int nr, input int nf, input int no, input bit bw,
                      input bit ignored);
    exp_t e;
    if (!ignored) begin
      while (busy) @(negedge clk);
      if (inRange(nr, nf, no)) begin
        mNr = nr - 1; mNo = no - 1; mNf = nf - 1;
        if (bw) mBw = (nf >> 1) - 1;
        mSlow = !lockEn;
        e.isErr = !lockEn;
      end else begin
        e.isErr = 1;
      end
      e.nrE = mNr; e.noE = mNo; e.nfE = mNf; e.bwE = mBw; e.slowE = mSlow;
      q.push_back(e);
    end
    reqNr = 6'(nr); reqNf = 13'(nf); reqNo = 5'(no); reqBwAdj = bw;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: outcome scoreboard and ordering checks
  int  cyc = 0, fieldCyc = 0;
  bit  pSlow = 0, pRst = 0, pLock = 0;
  int  pFields = 0;
  bit  monOn = 0;
  always @(negedge clk) begin
    int curFields;
    exp_t e;
    cyc++;
    curFields = {nrField, noField, nfField};
    if (monOn) begin
      if (!pSlow && pllSlow) chk(busy, "R9 busy with slow", busy, 1);
      if (!pRst && pllReset) chk(pllSlow, "R2 slow before reset", pllSlow, 1);
      if (curFields != pFields) begin
        chk(pllReset, "R2 fields under reset", pllReset, 1);
        fieldCyc = cyc;
      end
      if (pRst && !pllReset) chk(cyc - fieldCyc == HOLD, "R5 hold", cyc - fieldCyc, HOLD);
      if (done) begin
        chk(pLock, "R8 lock before done", pLock, 1);
        chk(!pllSlow, "R8 normal mode", pllSlow, 0);
      end
      if (pSlow && !pllSlow) chk(done, "R8 slow drop with done", done, 1);
      if (done || err) begin
        if (q.size() == 0) chk(0, "R9 extra outcome", 1, 0);
        else begin
          e = q.pop_front();
          chk(err == e.isErr, "R9 outcome kind err", err, e.isErr);
          chk(!busy, "R9 busy low", busy, 0);
          chk(nrField == e.nrE && noField == e.noE && nfField == e.nfE,
              "R3 fields", curFields, {e.nrE[5:0], e.noE[3:0], e.nfE[12:0]});
          chk(bwField == e.bwE, "R4 bw", bwField, e.bwE);
          chk(pllSlow == e.slowE, "R10 slow state", pllSlow, e.slowE);
        end
      end
    end
    pSlow = pllSlow; pRst = pllReset; pLock = pllLock; pFields = curFields;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!pllSlow && !pllReset && !busy && !done && !err, "R1 controls", pllSlow, 0);
    chk({nrField, noField, nfField, bwField} == '0, "R1 fields",
        int'({nrField, noField, nfField}), 0);
    monOn = 1;

    send(1, 50, 2, 0, 0); drain();    // R3, R4 unchanged bw
    send(1, 67, 1, 1, 0); drain();    // R4 bw written
    send(9, 400, 2, 1, 0); drain();
    send(1, 50, 3, 1, 0); drain();    // R6 odd NO
    send(1, 50, 18, 1, 0); drain();   // R6 NO above field range
    send(3, 54, 2, 1, 0); drain();    // R7 VCO below minimum
    send(3, 55, 2, 0, 0); drain();    // R7 VCO exactly minimum
    send(1, 100, 1, 1, 0); drain();   // R7 VCO above maximum
    send(1, 20, 16, 1, 0); drain();   // R7 output exactly minimum
    send(1, 19, 16, 1, 0); drain();   // R7 output below minimum
    // R9: second request while busy is ignored
    send(2, 100, 2, 1, 0);
    repeat (3) @(negedge clk);
    send(1, 60, 2, 1, 1);
    drain();
    // R10: lock never comes
    lockEn = 1'b0;
    send(2, 80, 2, 1, 0); drain();
    lockEn = 1'b1;
    send(1, 40, 2, 1, 0); drain();
    chk(q.size() == 0, "R9 all outcomes seen", q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule